// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for a configurable number of pins, grouped into 32-pin banks. For every bank, software can read and write seven registers. They set each pin's enable, drive value and direction, read back the synchronized pad level, mask its interrupt, select the active edge, and inspect and acknowledge latched events. Output pins drive their data bit onto the pad with an output enable. Every pad passes through a two-flop synchronizer before it is sampled or checked for edges.

An edge on an enabled, unmasked pin sets that pin's status bit. All status bits across all banks are ORed into one registered interrupt line. A build-time parameter removes the edge-select register. In that build, a status bit is set on every cycle in which the enabled, unmasked input is high.

The register bus is a single-cycle port. A write takes effect at the clock edge where select and write are both high. Read data is combinational from the address while select is high.

Top module: `banked_gpio`

## Requirements
- R1: Byte address bits [7:5] pick the register kind: 0 enable, 1 drive data, 2 direction, 3 pad level (read-only), 4 interrupt mask, 5 event status, 6 edge select, 7 unmapped. Bits [4:2] pick the bank. Pin n lives in bank n/32 at bit n%32.
- R2: After synchronous reset, every register reads 0 except direction. Direction reads 1 for every existing pin. The interrupt line is low and no pin is driven.
- R3: A pin is driven (pin_oe=1) exactly when its enable bit is 1 and its direction bit is 0 (0 = output, 1 = input). pin_out carries the drive-data bit while driven and is 0 otherwise.
- R4: The pad-level register shows the pad value delayed by two clock edges, ANDed with the enable bit.
- R5: With edge select 1, a rising pad edge sets the status bit. With edge select 0, a falling edge sets it. Only enabled pins raise events. The status bit reads set after the third clock edge following the pad change.
- R6: An interrupt-mask bit of 1 stops that pin from setting its status bit; 0 lets it.
- R7: A status write clears every bit written as 0 and keeps every bit written as 1.
- R8: When a new event and a clearing write hit the same status bit at the same edge, the bit stays set.
- R9: The interrupt line is the OR of all status bits, registered, so it rises one edge after a status bit is set.
- R10: In the last bank, bits above the pin count read 0 in every register, ignore writes and never set status.
- R11: With the edge-select parameter off, the edge-select register reads 0 and ignores writes. A status bit is set on every edge at which its enabled, unmasked synchronized input is high, so clearing it while the input stays high does not hold.
- R12: Writes to the pad-level register, to kind 7 and to any address with bits [1:0] nonzero have no effect. Such reads return 0, as does any read with select low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| pin_in | input | NUM_PINS | Pad input levels |
| pin_out | output | NUM_PINS | Pad drive values |
| pin_oe | output | NUM_PINS | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench goes after several corner cases. It fires an edge exactly in the cycle of an acknowledging write; a design that let the clear win would lose an event. It measures the input path cycle by cycle, so an extra or missing synchronizer stage, or an unregistered interrupt, shows up as an off-by-one. It writes all ones to the partial last bank and expects the phantom bits to stay 0. It holds a level input high through a clear, which a level build that latched only once would fail. Random register traffic and pad changes are compared against a bench model of the status, mask and edge semantics.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BANK_W = 32;
    localparam int ADDR_W = 8;

    typedef enum logic [2:0] {
        RK_EN    = 3'd0,
        RK_DOUT  = 3'd1,
        RK_DIR   = 3'd2,
        RK_DIN   = 3'd3,
        RK_IMASK = 3'd4,
        RK_ISTAT = 3'd5,
        RK_ESEL  = 3'd6,
        RK_NONE  = 3'd7
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [2:0]  bank;
        logic        aligned;
    } bus_dec_t;

    typedef struct packed {
        logic [BANK_W-1:0] en;
        logic [BANK_W-1:0] dout;
        logic [BANK_W-1:0] dir;
        logic [BANK_W-1:0] imask;
        logic [BANK_W-1:0] esel;
        logic [BANK_W-1:0] stat;
    } bank_regs_t;

    function automatic bus_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        bus_dec_t d;
        d.kind    = reg_kind_e'(a[7:5]);
        d.bank    = a[4:2];
        d.aligned = (a[1:0] == 2'b00);
        return d;
    endfunction

    function automatic logic [BANK_W-1:0] valid_mask(input int bank, input int npins);
        logic [BANK_W-1:0] m;
        for (int i = 0; i < BANK_W; i++)
            m[i] = ((bank * BANK_W + i) < npins);
        return m;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int BANK_IDX    = 0,
    parameter int NUM_PINS    = 32,
    parameter bit EDGE_SEL_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_kind_e         kind,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] pad_in,
    output logic [BANK_W-1:0] rdata,
    output logic [BANK_W-1:0] pad_out,
    output logic [BANK_W-1:0] pad_oe,
    output logic              stat_any
);
    localparam logic [BANK_W-1:0] VALID = valid_mask(BANK_IDX, NUM_PINS);

    bank_regs_t        r;
    logic [BANK_W-1:0] sync_q;
    logic [BANK_W-1:0] trig;
    logic [BANK_W-1:0] evt;
    logic [BANK_W-1:0] keep;

    gpio_sync2 #(.W(BANK_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in & VALID),
        .q   (sync_q)
    );

    generate
        if (EDGE_SEL_EN) begin : g_edge
            logic [BANK_W-1:0] prev;
            always_ff @(posedge clk) begin
                if (rst) prev <= '0;
                else     prev <= sync_q;
            end
            assign trig = (r.esel & sync_q & ~prev) | (~r.esel & ~sync_q & prev);
        end else begin : g_level
            assign trig = sync_q;
        end
    endgenerate

    assign evt  = trig & r.en & ~r.imask & VALID;
    assign keep = (wr_en && kind == RK_ISTAT) ? wdata : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            r     <= '0;
            r.dir <= VALID;
        end else begin
            if (wr_en) begin
                case (kind)
                    RK_EN:    r.en    <= wdata & VALID;
                    RK_DOUT:  r.dout  <= wdata & VALID;
                    RK_DIR:   r.dir   <= wdata & VALID;
                    RK_IMASK: r.imask <= wdata & VALID;
                    RK_ESEL:  if (EDGE_SEL_EN) r.esel <= wdata & VALID;
                    default:  ;
                endcase
            end
            r.stat <= (r.stat & keep) | evt;
        end
    end

    always_comb begin
        case (kind)
            RK_EN:    rdata = r.en;
            RK_DOUT:  rdata = r.dout;
            RK_DIR:   rdata = r.dir;
            RK_DIN:   rdata = sync_q & r.en;
            RK_IMASK: rdata = r.imask;
            RK_ISTAT: rdata = r.stat;
            RK_ESEL:  rdata = r.esel;
            default:  rdata = '0;
        endcase
    end

    assign pad_oe   = r.en & ~r.dir;
    assign pad_out  = r.dout & pad_oe;
    assign stat_any = |r.stat;

    a_r2_dir_reset: assert property (@(posedge clk)
        $fell(rst) |-> r.dir == VALID);

    a_r6_set_needs_unmasked: assert property (@(posedge clk) disable iff (rst)
        ((r.stat & ~$past(r.stat)) & ~$past(r.en & ~r.imask)) == '0);

    a_r7_clear_by_zero: assert property (@(posedge clk) disable iff (rst)
        (wr_en && kind == RK_ISTAT && evt == '0) |=> r.stat == ($past(r.stat & wdata) & VALID));

    a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> (r.stat & $past(evt)) == $past(evt));

    a_r10_phantom_quiet: assert property (@(posedge clk) disable iff (rst)
        ((r.en | r.dout | r.dir | r.imask | r.esel | r.stat) & ~VALID) == '0);
endmodule

// File: rtl/banked_gpio.sv
module banked_gpio
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS    = 40,
    parameter bit EDGE_SEL_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [7:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
    localparam int PAD_W     = NUM_BANKS * BANK_W;

    bus_dec_t           dec;
    logic [PAD_W-1:0]   pad_in;
    logic [PAD_W-1:0]   pad_out;
    logic [PAD_W-1:0]   pad_oe;
    logic [BANK_W-1:0]  bank_rd  [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_any;

    assign dec = decode_addr(bus_addr);

    generate
        for (genvar i = 0; i < PAD_W; i++) begin : g_pad
            if (i < NUM_PINS) begin : g_real
                assign pad_in[i] = pin_in[i];
            end else begin : g_fill
                assign pad_in[i] = 1'b0;
            end
        end

        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            gpio_bank #(
                .BANK_IDX    (b),
                .NUM_PINS    (NUM_PINS),
                .EDGE_SEL_EN (EDGE_SEL_EN)
            ) u_bank (
                .clk      (clk),
                .rst      (rst),
                .wr_en    (bus_sel && bus_wr && dec.aligned && dec.bank == 3'(b)),
                .kind     (dec.kind),
                .wdata    (bus_wdata),
                .pad_in   (pad_in[b*BANK_W +: BANK_W]),
                .rdata    (bank_rd[b]),
                .pad_out  (pad_out[b*BANK_W +: BANK_W]),
                .pad_oe   (pad_oe[b*BANK_W +: BANK_W]),
                .stat_any (bank_any[b])
            );
        end
    endgenerate

    assign pin_out = pad_out[NUM_PINS-1:0];
    assign pin_oe  = pad_oe[NUM_PINS-1:0];

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && dec.aligned) begin
            for (int b = 0; b < NUM_BANKS; b++)
                if (dec.bank == 3'(b)) bus_rdata = bank_rd[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |bank_any;
    end

    a_r9_irq_tracks_status: assert property (@(posedge clk) disable iff (rst)
        irq == $past(|bank_any));

    a_r10_pad_fill_idle: assert property (@(posedge clk) disable iff (rst)
        ((pad_out | pad_oe) >> NUM_PINS) == '0);

    a_r3_drive_only_outputs: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~pin_oe) == '0);
endmodule

// File: tb/banked_gpio_test.sv
`timescale 1ns/1ps
module banked_gpio_test;
    localparam int NP = 40;
    localparam int NB = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, lvl_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe, lvl_out, lvl_oe;
    logic        irq, lvl_irq;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    logic [31:0] m_en[NB], m_dout[NB], m_dir[NB], m_imask[NB], m_esel[NB], m_stat[NB];

    always #2.5 clk = ~clk;

    banked_gpio #(.NUM_PINS(NP), .EDGE_SEL_EN(1'b1)) uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

    banked_gpio #(.NUM_PINS(NP), .EDGE_SEL_EN(1'b0)) uut_lvl (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(lvl_rdata), .pin_in(pin_in),
        .pin_out(lvl_out), .pin_oe(lvl_oe), .irq(lvl_irq));

    function automatic logic [31:0] vmask(input int b);
        logic [31:0] m;
        for (int i = 0; i < 32; i++) m[i] = (b * 32 + i) < NP;
        return m;
    endfunction

    function automatic logic [31:0] pins_of(input logic [NP-1:0] p, input int b);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = ((b * 32 + i) < NP) ? p[b * 32 + i] : 1'b0;
        return r;
    endfunction

    function automatic logic [7:0] addr_of(input int kind, input int b);
        return {3'(kind), 3'(b), 2'b00};
    endfunction

    function automatic logic [31:0] exp_read(input int kind, input int b);
        case (kind)
            0: return m_en[b];
            1: return m_dout[b];
            2: return m_dir[b];
            3: return pins_of(pin_in, b) & m_en[b];
            4: return m_imask[b];
            5: return m_stat[b];
            6: return m_esel[b];
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_write(input int kind, input int b, input logic [31:0] d);
        logic [31:0] v;
        v = d & vmask(b);
        case (kind)
            0: m_en[b] = v;
            1: m_dout[b] = v;
            2: m_dir[b] = v;
            4: m_imask[b] = v;
            5: m_stat[b] = m_stat[b] & d;
            6: m_esel[b] = v;
            default: ;
        endcase
    endtask

    task automatic raw_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic reg_write(input int kind, input int b, input logic [31:0] d);
        raw_write(addr_of(kind, b), d);
        model_write(kind, b, d);
    endtask

    task automatic raw_read(input logic [7:0] a, output logic [31:0] d, output logic [31:0] dl);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        d = bus_rdata; dl = lvl_rdata;
        bus_sel = 0;
    endtask

    task automatic read_check(input string req, input int kind, input int b);
        logic [31:0] d, dl;
        raw_read(addr_of(kind, b), d, dl);
        check(req, d, exp_read(kind, b));
    endtask

    task automatic apply_pins(input logic [NP-1:0] nv);
        for (int b = 0; b < NB; b++) begin
            logic [31:0] o, n, ev;
            o = pins_of(pin_in, b);
            n = pins_of(nv, b);
            ev = m_en[b] & ~m_imask[b] & ((m_esel[b] & ~o & n) | (~m_esel[b] & o & ~n));
            m_stat[b] = m_stat[b] | ev;
        end
        @(negedge clk);
        pin_in = nv;
        repeat (5) @(negedge clk);
    endtask

    task automatic check_outputs(input string tag);
        logic [NP-1:0] eo, ev;
        logic any;
        @(negedge clk);
        any = 0;
        for (int i = 0; i < NP; i++) begin
            eo[i] = m_en[i / 32][i % 32] & ~m_dir[i / 32][i % 32];
            ev[i] = eo[i] & m_dout[i / 32][i % 32];
        end
        for (int b = 0; b < NB; b++) any = any | (|m_stat[b]);
        check({tag, " R3 pin_oe"}, 64'(pin_oe), 64'(eo));
        check({tag, " R3 pin_out"}, 64'(pin_out), 64'(ev));
        check({tag, " R9 irq"}, 64'(irq), 64'(any));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, dl;
        void'($urandom(32'h1234_5eed));
        for (int b = 0; b < NB; b++) begin
            m_en[b] = 0; m_dout[b] = 0; m_dir[b] = vmask(b);
            m_imask[b] = 0; m_esel[b] = 0; m_stat[b] = 0;
        end
        repeat (4) @(negedge clk);
        rst = 0;

        // R2 reset state, R1 map for every kind and bank
        for (int b = 0; b < NB; b++)
            for (int k = 0; k < 8; k++) read_check("R2 reset value (R1 map)", k, b);
        check("R2 irq after reset", 64'(irq), 64'(0));
        check("R2 pin_oe after reset", 64'(pin_oe), 64'(0));

        // R4/R5/R9 cycle timing on pin 3, rising edge
        reg_write(0, 0, 32'h0000_0008);
        reg_write(6, 0, 32'h0000_0008);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = addr_of(3, 0);
        pin_in[3] = 1'b1;
        @(posedge clk); #1;
        check("R4 pad level after 1 edge", 64'(bus_rdata[3]), 64'(0));
        @(posedge clk); #1;
        check("R4 pad level after 2 edges", 64'(bus_rdata[3]), 64'(1));
        @(posedge clk); #1;
        check("R9 irq not yet at status edge", 64'(irq), 64'(0));
        @(posedge clk); #1;
        check("R9 irq one edge after status", 64'(irq), 64'(1));
        bus_sel = 0;
        m_stat[0] = 32'h8;
        read_check("R5 rising edge latched", 5, 0);

        // R7 acknowledge by writing complement
        reg_write(5, 0, ~32'h8);
        read_check("R7 status cleared by zero", 5, 0);
        check_outputs("R7 ack");

        // R8 event and clearing write at the same edge
        apply_pins(pin_in & ~40'h8);
        @(negedge clk);
        pin_in[3] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = addr_of(5, 0); bus_wdata = 32'h0;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        m_stat[0] = 32'h8;
        read_check("R8 new event wins over clear", 5, 0);
        reg_write(5, 0, 32'h0);

        // R6 masked pin, then R5 falling edge
        reg_write(4, 0, 32'h8);
        apply_pins(pin_in & ~40'h8);
        read_check("R6 masked edge ignored", 5, 0);
        reg_write(4, 0, 32'h0);
        reg_write(6, 0, 32'h0);
        apply_pins(pin_in | 40'h8);
        read_check("R5 rising ignored in falling mode", 5, 0);
        apply_pins(pin_in & ~40'h8);
        read_check("R5 falling edge latched", 5, 0);
        reg_write(5, 0, 32'h0);

        // R3 drive and release pin 5
        reg_write(0, 0, 32'h28);
        reg_write(2, 0, ~32'h20);
        reg_write(1, 0, 32'h20);
        check_outputs("R3 drive high");
        reg_write(0, 0, 32'h08);
        check_outputs("R3 disabled pin released");

        // R10 phantom bits of last bank
        for (int k = 0; k < 7; k++) begin
            if (k != 5) reg_write(k, 1, 32'hFFFF_FFFF);
            read_check("R10 last bank upper bits zero", k, 1);
        end
        reg_write(4, 1, 32'h0);
        reg_write(2, 1, 32'hFFFF_FFFF);

        // R12 ignored accesses
        reg_write(3, 0, 32'hFFFF_FFFF);
        read_check("R12 pad-level write ignored", 3, 0);
        raw_write(8'h01, 32'hFFFF_FFFF);
        read_check("R12 unaligned write ignored", 0, 0);
        raw_read(8'h01, d, dl);
        check("R12 unaligned read zero", 64'(d), 64'(0));
        raw_write(addr_of(7, 0), 32'hFFFF_FFFF);
        read_check("R12 unmapped kind reads zero", 7, 0);
        @(negedge clk);
        bus_addr = addr_of(2, 0); #1;
        check("R12 read without select", 64'(bus_rdata), 64'(0));

        // R1 random register and pin traffic against the model
        for (int it = 0; it < 300; it++) begin
            int op, k, b;
            op = $urandom % 4;
            b = $urandom % NB;
            k = $urandom % 7;
            if (op == 0) begin
                reg_write(k, b, $urandom);
                check_outputs("R1 random write");
            end else if (op == 1) begin
                apply_pins({$urandom, $urandom});
                check_outputs("R5 random pins");
            end else begin
                read_check("R1 random readback", k, b);
            end
        end

        // R11 level-only build
        for (int b = 0; b < NB; b++) begin
            reg_write(4, b, 32'hFFFF_FFFF);
            reg_write(5, b, 32'h0);
        end
        reg_write(0, 0, 32'h80);
        reg_write(2, 0, 32'hFFFF_FFFF);
        reg_write(6, 0, 32'hFFFF_FFFF);
        raw_read(addr_of(6, 0), d, dl);
        check("R11 level build edge select reads 0", 64'(dl), 64'(0));
        apply_pins(pin_in & ~40'h80);
        reg_write(5, 0, 32'h0);
        reg_write(4, 0, ~32'h80);
        apply_pins(pin_in | 40'h80);
        raw_read(addr_of(5, 0), d, dl);
        check("R11 level high sets status", 64'(dl[7]), 64'(1));
        check("R11 level irq", 64'(lvl_irq), 64'(1));
        reg_write(5, 0, 32'h0);
        raw_read(addr_of(5, 0), d, dl);
        check("R11 clear while high re-sets", 64'(dl[7]), 64'(1));
        apply_pins(pin_in & ~40'h80);
        reg_write(5, 0, 32'h0);
        raw_read(addr_of(5, 0), d, dl);
        check("R11 clear after low holds", 64'(dl), 64'(0));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule